// File: doc/BRIEF.md
# RTC Seconds Counter with Alarm

This core keeps wall-clock time as a plain 32-bit count of seconds. It runs from a slow timebase clock. A programmable prescaler divides that clock down to one tick per second, and each tick advances the seconds count when counting is enabled. A 32-bit alarm value is compared with the count on every tick. Two sticky event flags, one for the per-second tick and one for the alarm match, each have an interrupt enable and together drive a single interrupt line. A free 32-bit scratch register keeps whatever software stores in it.

All registers sit on a simple 32-bit register bus. The bus has a write strobe, a byte address and write data, and read data is decoded combinationally from the address. Writes to the timekeeping registers are protected. Software first polls a write-ready bit. It then stores a key value into an unlock register, and only then may it make one protected write. Each accepted write re-arms the lock and makes the core busy for a short while.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0x80 (only write-ready set). The seconds count at 0x04, the alarm at 0x08, the scratch register at 0x34 and the unlock register at 0x3C all read 0. The prescaler at 0x0C reads 32767, and the interrupt output is low.
- R2: A write of 0x0000A55A to offset 0x3C sets bit 31 of that register (write enabled). A write of any other value to 0x3C leaves that bit unchanged.
- R3: A write to offsets 0x00, 0x04, 0x08, 0x0C or 0x34 while bit 31 of 0x3C is clear changes nothing. An accepted write clears bit 31, so each unlock allows exactly one write.
- R4: Control bit 7 (write-ready) is read-only. It reads 0 for the 4 cycles after an accepted write. A protected write made while it is 0 is ignored and does not clear the unlock bit.
- R5: The prescaler register holds N-1. While control bit 0 (count enable) is 1, the seconds count rises by one every N clock cycles. The first step comes N cycles after the edge that set the enable.
- R6: While control bit 0 is 0, the seconds count holds its value.
- R7: Writing the seconds register loads the written value and restarts the prescaler, so the next step comes exactly N cycles after that write.
- R8: Control bit 6 (second flag) is set on every step. Control bit 4 (alarm flag) is set on a step whose new seconds value equals the alarm register, but only if control bit 2 (alarm enable) is 1.
- R9: Each flag is cleared only by writing 0 to its bit; writing 1 leaves it as it was. If a step falls in the same cycle as a write that clears bit 6, the flag ends up set.
- R10: The interrupt output is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of the control word are both set. Bit 5 enables the second interrupt and bit 3 enables the alarm interrupt.
- R11: The scratch register and the alarm register read back any 32-bit value accepted into them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow timebase clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can land on the same edge. One is a per-second step that sets the second flag. The other is a software write to the control word that clears that flag. The bench enables counting with the prescaler at N-1 = 4, counts edges from that write, and times the unlock and the clearing control write to land on the fifth edge. That edge is the step edge. The flag must read 1 afterwards. A second case puts a seconds reload on a running counter and checks the new value at the fourth and fifth edges after it, so that a step dropped or doubled at the reload would show up.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    localparam int          DATA_W     = 32;
    localparam int          ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SECS    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ALARM   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PRE     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_UNLOCK  = 8'h3C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0000_A55A;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_SECS,
        SEL_ALARM,
        SEL_PRE,
        SEL_SCRATCH,
        SEL_UNLOCK
    } reg_sel_e;

    typedef struct packed {
        logic f1;    // second flag
        logic ie1;   // second interrupt enable
        logic fa;    // alarm flag
        logic iea;   // alarm interrupt enable
        logic ae;    // alarm enable
        logic en;    // count enable
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:    s = SEL_CTRL;
            OFS_SECS:    s = SEL_SECS;
            OFS_ALARM:   s = SEL_ALARM;
            OFS_PRE:     s = SEL_PRE;
            OFS_SCRATCH: s = SEL_SCRATCH;
            OFS_UNLOCK:  s = SEL_UNLOCK;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_guarded(input reg_sel_e s);
        return (s != SEL_NONE) && (s != SEL_UNLOCK);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic rdy);
        return {24'h0, rdy, c.f1, c.ie1, c.fa, c.iea, c.ae, 1'b0, c.en};
    endfunction

endpackage

// File: rtl/rtc_wr_guard.sv
module rtc_wr_guard #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic hit_unlock,
    input  logic key_ok,
    input  logic hit_guarded,
    output logic accept,
    output logic wen,
    output logic ready
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] hold_q;

    assign ready  = (hold_q == '0);
    assign accept = wr_stb && hit_guarded && wen && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wen    <= 1'b0;
            hold_q <= '0;
        end else if (accept) begin
            wen    <= 1'b0;
            hold_q <= CW'(HOLD);
        end else begin
            if (wr_stb && hit_unlock && key_ok)
                wen <= 1'b1;
            if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q >= limit);
    assign tick = run && wrap && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            cnt_q <= '0;
        else if (wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
    import rtc_sec_pkg::*;
#(
    parameter int          PRE_W    = 32,
    parameter int unsigned PRE_INIT = 32767,
    parameter int          WR_HOLD  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    reg_sel_e          sel;
    logic              wr_accept, wr_en, wr_ready;
    logic              wr_ctrl, wr_secs, wr_alarm, wr_pre, wr_scratch;
    logic              tick;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] secs_q, alarm_q, scratch_q, secs_inc;
    logic [PRE_W-1:0]  pre_q;

    assign sel = decode_addr(bus_addr);

    rtc_wr_guard #(.HOLD(WR_HOLD)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (bus_wr),
        .hit_unlock (sel == SEL_UNLOCK),
        .key_ok     (bus_wdata == UNLOCK_KEY),
        .hit_guarded(is_guarded(sel)),
        .accept     (wr_accept),
        .wen        (wr_en),
        .ready      (wr_ready)
    );

    assign wr_ctrl    = wr_accept && (sel == SEL_CTRL);
    assign wr_secs    = wr_accept && (sel == SEL_SECS);
    assign wr_alarm   = wr_accept && (sel == SEL_ALARM);
    assign wr_pre     = wr_accept && (sel == SEL_PRE);
    assign wr_scratch = wr_accept && (sel == SEL_SCRATCH);

    rtc_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.en),
        .restart(wr_secs),
        .limit  (pre_q),
        .tick   (tick)
    );

    assign secs_inc = secs_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            secs_q    <= '0;
            alarm_q   <= '0;
            pre_q     <= PRE_W'(PRE_INIT);
            scratch_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.ie1 <= bus_wdata[5];
                ctrl_q.iea <= bus_wdata[3];
                ctrl_q.ae  <= bus_wdata[2];
                ctrl_q.en  <= bus_wdata[0];
                ctrl_q.f1  <= ctrl_q.f1 & bus_wdata[6];
                ctrl_q.fa  <= ctrl_q.fa & bus_wdata[4];
            end
            if (tick) begin
                ctrl_q.f1 <= 1'b1;
                if (ctrl_q.ae && (secs_inc == alarm_q))
                    ctrl_q.fa <= 1'b1;
            end
            if (wr_secs)
                secs_q <= bus_wdata;
            else if (tick)
                secs_q <= secs_inc;
            if (wr_alarm)
                alarm_q <= bus_wdata;
            if (wr_pre)
                pre_q <= bus_wdata[PRE_W-1:0];
            if (wr_scratch)
                scratch_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL:    bus_rdata = pack_ctrl(ctrl_q, wr_ready);
            SEL_SECS:    bus_rdata = secs_q;
            SEL_ALARM:   bus_rdata = alarm_q;
            SEL_PRE:     bus_rdata[PRE_W-1:0] = pre_q;
            SEL_SCRATCH: bus_rdata = scratch_q;
            SEL_UNLOCK:  bus_rdata[31] = wr_en;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_o = (ctrl_q.f1 && ctrl_q.ie1) || (ctrl_q.fa && ctrl_q.iea);

endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk
    import rtc_sec_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        accept,
    input logic        wen,
    input logic        ready,
    input logic        tick,
    input logic        wr_ctrl,
    input logic        wr_secs,
    input logic        guarded_wr,
    input ctrl_t       ctrl,
    input logic [31:0] secs,
    input logic [31:0] scratch,
    input logic        irq
);
    a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
        accept |=> !wen);

    a_r3_locked_ignored: assert property (@(posedge clk) disable iff (rst)
        (guarded_wr && !wen) |=> $stable(scratch));

    a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_secs) |=> (secs == $past(secs) + 32'd1));

    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en && !wr_secs) |=> $stable(secs));

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl.f1 && !wr_ctrl) |=> ctrl.f1);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        tick |=> ctrl.f1);

    a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.f1 || ctrl.fa));
endmodule

bind rtc_sec_core rtc_sec_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (wr_accept),
    .wen       (wr_en),
    .ready     (wr_ready),
    .tick      (tick),
    .wr_ctrl   (wr_ctrl),
    .wr_secs   (wr_secs),
    .guarded_wr(bus_wr && is_guarded(sel)),
    .ctrl      (ctrl_q),
    .secs      (secs_q),
    .scratch   (scratch_q),
    .irq       (irq_o)
);

// File: tb/rtc_sec_core_tb_top.sv
`timescale 1ns/1ps
module rtc_sec_core_tb_top;
    localparam logic [7:0]  A_CTRL = 8'h00, A_SECS = 8'h04, A_ALRM = 8'h08;
    localparam logic [7:0]  A_PRE  = 8'h0C, A_SCR  = 8'h34, A_UNLK = 8'h3C;
    localparam logic [31:0] KEY    = 32'h0000_A55A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_sec_core dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] ctrl_exp(input logic rdy, f1, ie1, fa, iea, ae, en);
        return {24'h0, rdy, f1, ie1, fa, iea, ae, 1'b0, en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, consumed at the next posedge
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d);
        bus_wr = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            rd(A_CTRL, v);
            if (v[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic pwr(input logic [7:0] a, input logic [31:0] d);
        wait_ready();
        cyc(1'b1, A_UNLK, KEY);
        cyc(1'b1, a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, s0, rnd;
        rnd = $urandom(32'd1234);
        idle(3);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h80);
        rd(A_SECS, v); chk("R1 secs", v, 0);
        rd(A_ALRM, v); chk("R1 alarm", v, 0);
        rd(A_PRE,  v); chk("R1 prescaler", v, 32767);
        rd(A_SCR,  v); chk("R1 scratch", v, 0);
        rd(A_UNLK, v); chk("R1 unlock", v, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);

        // R3 locked write ignored
        cyc(1'b1, A_SCR, 32'hDEAD_BEEF);
        rd(A_SCR, v); chk("R3 locked scratch", v, 0);

        // R2 wrong key, right key
        cyc(1'b1, A_UNLK, 32'h0000_1234);
        rd(A_UNLK, v); chk("R2 wrong key", v, 0);
        cyc(1'b1, A_UNLK, KEY);
        rd(A_UNLK, v); chk("R2 key sets bit31", v, 32'h8000_0000);

        // R3 accepted write consumes the unlock
        cyc(1'b1, A_SCR, 32'h11);
        rd(A_SCR, v);  chk("R3 accepted", v, 32'h11);
        rd(A_UNLK, v); chk("R3 unlock cleared", v, 0);

        // R4 busy window after accepted write at edge W
        rd(A_CTRL, v); chk("R4 ready low", {31'b0, v[7]}, 0);
        cyc(1'b1, A_UNLK, KEY);          // W+1
        cyc(1'b1, A_SCR, 32'h33);        // W+2, not ready
        rd(A_SCR, v);  chk("R4 busy write ignored", v, 32'h11);
        rd(A_UNLK, v); chk("R4 unlock kept", v, 32'h8000_0000);
        idle(1);                          // after W+3
        rd(A_CTRL, v); chk("R4 ready still low", {31'b0, v[7]}, 0);
        idle(1);                          // after W+4
        rd(A_CTRL, v); chk("R4 ready back", {31'b0, v[7]}, 1);
        cyc(1'b1, A_SCR, 32'h33);
        rd(A_SCR, v);  chk("R4 write after ready", v, 32'h33);

        // R3 write without a fresh unlock
        wait_ready();
        cyc(1'b1, A_SCR, 32'h22);
        rd(A_SCR, v); chk("R3 relocked", v, 32'h33);

        // R11 random readback
        for (int i = 0; i < 6; i++) begin
            rnd = $urandom;
            pwr(A_SCR, rnd);
            rd(A_SCR, v); chk("R11 scratch", v, rnd);
            rnd = $urandom;
            pwr(A_ALRM, rnd);
            rd(A_ALRM, v); chk("R11 alarm", v, rnd);
        end

        // R5 stepping with N = 5
        pwr(A_PRE, 32'd4);
        rd(A_PRE, v); chk("R5 prescaler", v, 4);
        pwr(A_SECS, 32'd100);
        pwr(A_CTRL, 32'h01);             // edge E
        idle(4);
        rd(A_SECS, v); chk("R5 before first step", v, 100);
        idle(1);
        rd(A_SECS, v); chk("R5 first step", v, 101);
        rd(A_CTRL, v); chk("R8 second flag", {31'b0, v[6]}, 1);
        idle(5);
        rd(A_SECS, v); chk("R5 second step", v, 102);
        idle(25);
        rd(A_SECS, v); chk("R5 five more", v, 107);

        // R7 reload on a running counter
        pwr(A_SECS, 32'd1000);           // edge E0
        idle(4);
        rd(A_SECS, v); chk("R7 loaded", v, 1000);
        idle(1);
        rd(A_SECS, v); chk("R7 restart step", v, 1001);

        // R6 hold while disabled, flag cleared by 0
        pwr(A_CTRL, 32'h00);
        rd(A_CTRL, v); chk("R9 clear by zero", v & 32'h7F, 0);
        rd(A_SECS, s0);
        idle(20);
        rd(A_SECS, v); chk("R6 hold", v, s0);

        // R9 step and clearing write on the same edge
        pwr(A_CTRL, 32'h01);             // edge E1, counter from 0
        cyc(1'b1, A_UNLK, KEY);          // E1+1
        idle(3);                          // E1+2..E1+4
        cyc(1'b1, A_CTRL, 32'h01);       // E1+5 = step edge, clears bit 6
        rd(A_CTRL, v); chk("R9 set wins", {31'b0, v[6]}, 1);

        // R9 writing 1 keeps flag
        pwr(A_CTRL, 32'h40);             // stop, keep flag
        pwr(A_CTRL, 32'h40);
        rd(A_CTRL, v); chk("R9 write one keeps", {31'b0, v[6]}, 1);
        pwr(A_CTRL, 32'h00);
        rd(A_CTRL, v); chk("R9 write zero clears", {31'b0, v[6]}, 0);

        // R8 / R10 alarm
        pwr(A_SECS, 32'd2000);
        pwr(A_ALRM, 32'd2002);
        pwr(A_CTRL, 32'h0D);             // en, alarm enable, alarm irq enable
        idle(9);
        rd(A_CTRL, v); chk("R8 no early alarm", {31'b0, v[4]}, 0);
        chk("R10 irq low", {31'b0, irq_o}, 0);
        idle(1);
        rd(A_SECS, v); chk("R8 at alarm", v, 2002);
        rd(A_CTRL, v); chk("R8 alarm flag", v & 32'h7F, ctrl_exp(0, 1, 0, 1, 1, 1, 1));
        chk("R10 irq alarm", {31'b0, irq_o}, 1);
        pwr(A_CTRL, 32'h49);             // clear alarm flag, keep second flag
        chk("R10 irq off", {31'b0, irq_o}, 0);
        pwr(A_CTRL, 32'h61);             // enable second interrupt
        chk("R10 irq second", {31'b0, irq_o}, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule